// File: doc/BRIEF.md
# Load-Reserved / Store-Conditional Reservation Monitor

This block sits beside a memory port and decides which conditional stores may complete. A load-locked access records a reservation for the context that issued it. A context is one (CPU, thread) pair. The reservation covers one aligned 16-byte granule. Any later store that lands in that granule cancels every reservation held on it, whoever holds them. A conditional store completes only while its own context still holds a reservation on the target granule.

Each access is one cycle with `acc_vld` high. The write permit comes back combinationally in that same cycle, so the memory array can gate its write. For conditional stores, a registered done flag and a pass/fail bit appear on the following cycle. The table has a fixed number of slots. When a new context asks for a reservation and no slot is free, the least recently reserved slot is replaced.

Top module: `rsv_monitor`

## Requirements
- R1: Addresses are compared per granule, with the low GRAN_BITS (default 4) address bits ignored. A conditional store to any byte of a reserved 16-byte granule matches that reservation.
- R2: A context holds at most one reservation. A load-locked from a context that already holds one moves that reservation to the new granule, and the old granule is no longer reserved for it.
- R3: A load-locked from a context with no reservation takes a free slot. Reservations already held by other contexts stay intact.
- R4: Every store, plain or conditional and successful or not, cancels every reservation on the store's granule, including those held by other contexts.
- R5: A conditional store passes only if the requesting context holds a reservation on the store's granule. A reservation on that granule held by another context does not count.
- R6: `wr_permit` is high in the cycle of a valid store exactly when the store is plain or a passing conditional store. It is low for loads, for idle cycles and for failing conditional stores. A plain (non-locked) load changes no reservation.
- R7: With no reservation held, every conditional store fails and every plain store is permitted.
- R8: One cycle after a conditional store, `sc_done` is 1 and `sc_ok` is 1 on pass or 0 on fail. After any other cycle, `sc_done` and `sc_ok` are 0.
- R9: When all ENTRIES slots are held and a context without a reservation issues a load-locked, the slot that was least recently written by a load-locked is replaced. Refreshing a reservation counts as a write.
- R10: Reset drops every reservation and clears `sc_done` and `sc_ok`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_vld | input | 1 | Access strobe |
| acc_addr | input | ADDR_W | Physical byte address |
| acc_cpu | input | CPU_W | Requesting CPU number |
| acc_thr | input | THR_W | Requesting thread number within the CPU |
| acc_load | input | 1 | Access is a load |
| acc_store | input | 1 | Access is a store |
| acc_locked | input | 1 | Qualifier: load-locked or conditional store |
| wr_permit | output | 1 | Memory may perform this store (same cycle) |
| sc_done | output | 1 | A conditional store was handled in the previous cycle |
| sc_ok | output | 1 | Result of that conditional store: 1 pass, 0 fail |

## Verification
The assertions assume that `acc_load` and `acc_store` are never both high on a valid access. They also assume that the locked qualifier means nothing unless one of the two is set. The random stimulus draws one operation per cycle from a fixed menu: load-locked, plain load, plain store, conditional store or idle, so it never combines the flags. Addresses come from four granules with random low bits, and contexts come from eight (CPU, thread) pairs. This crowds the four-slot table, so granule collisions, cross-context cancellation and replacement of the oldest slot all happen often.

// File: rtl/rsv_pkg.sv
package rsv_pkg;

    // Where a load-locked reservation is placed
    typedef enum logic [1:0] {
        PLACE_REFRESH = 2'd0,   // context already owns a slot
        PLACE_FREE    = 2'd1,   // lowest-numbered empty slot
        PLACE_EVICT   = 2'd2    // table full, replace oldest
    } place_e;

    localparam int GRAN_BITS_DEF = 4;

endpackage

// File: rtl/rsv_slot_cmp.sv
module rsv_slot_cmp #(
    parameter int GRAN_W = 28,
    parameter int CPU_W  = 2,
    parameter int THR_W  = 2
) (
    input  logic              slot_vld,
    input  logic [GRAN_W-1:0] slot_gran,
    input  logic [CPU_W-1:0]  slot_cpu,
    input  logic [THR_W-1:0]  slot_thr,
    input  logic [GRAN_W-1:0] req_gran,
    input  logic [CPU_W-1:0]  req_cpu,
    input  logic [THR_W-1:0]  req_thr,
    output logic              gran_hit,
    output logic              ctx_hit
);

    always_comb begin
        gran_hit = slot_vld && (slot_gran == req_gran);
        ctx_hit  = slot_vld && (slot_cpu == req_cpu) && (slot_thr == req_thr);
    end

endmodule

// File: rtl/rsv_age_matrix.sv
module rsv_age_matrix #(
    parameter int N     = 4,
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             touch,
    input  logic [IDX_W-1:0] touch_idx,
    input  logic [N-1:0]     vld_mask,
    output logic [IDX_W-1:0] oldest_idx
);

    // older[i][j] = 1 : slot i was written before slot j
    typedef struct packed {
        logic [N-1:0][N-1:0] older;
    } age_st_t;

    age_st_t a_d, a_q;
    logic [N-1:0] is_old;

    always_comb begin
        a_d = a_q;
        if (touch) begin
            for (int j = 0; j < N; j++) begin
                a_d.older[touch_idx][j] = 1'b0;
                a_d.older[j][touch_idx] = (IDX_W'(j) != touch_idx);
            end
        end

        for (int i = 0; i < N; i++) begin
            is_old[i] = vld_mask[i];
            for (int j = 0; j < N; j++) begin
                if (j != i && vld_mask[j] && !a_q.older[i][j]) begin
                    is_old[i] = 1'b0;
                end
            end
        end

        oldest_idx = '0;
        for (int i = N-1; i >= 0; i--) begin
            if (is_old[i]) begin
                oldest_idx = IDX_W'(i);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q <= '0;
        end else begin
            a_q <= a_d;
        end
    end

    AST_ONE_OLDEST: assert property (@(posedge clk) disable iff (!rst_n)
        (|vld_mask) |-> ($countones(is_old) == 1)); // R9

endmodule

// File: rtl/rsv_monitor.sv
module rsv_monitor #(
    parameter int ADDR_W    = 32,
    parameter int CPU_W     = 2,
    parameter int THR_W     = 2,
    parameter int ENTRIES   = 4,
    parameter int GRAN_BITS = rsv_pkg::GRAN_BITS_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_vld,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [CPU_W-1:0]  acc_cpu,
    input  logic [THR_W-1:0]  acc_thr,
    input  logic              acc_load,
    input  logic              acc_store,
    input  logic              acc_locked,
    output logic              wr_permit,
    output logic              sc_done,
    output logic              sc_ok
);
    import rsv_pkg::*;

    localparam int GRAN_W = ADDR_W - GRAN_BITS;
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    typedef struct packed {
        logic              vld;
        logic [GRAN_W-1:0] gran;
        logic [CPU_W-1:0]  cpu;
        logic [THR_W-1:0]  thr;
    } slot_t;

    typedef struct packed {
        slot_t [ENTRIES-1:0] slot;
        logic                sc_done;
        logic                sc_ok;
    } mon_st_t;

    mon_st_t s_d, s_q;

    logic [GRAN_W-1:0]  req_gran;
    logic               unused_low;
    logic [ENTRIES-1:0] gran_hit;
    logic [ENTRIES-1:0] ctx_hit;
    logic [ENTRIES-1:0] vld_mask;
    logic               do_ll, do_st, do_sc, sc_pass;
    logic               free_found, own_found;
    logic [IDX_W-1:0]   free_idx, own_idx, oldest_idx, tgt_idx;
    place_e             place;

    assign req_gran   = acc_addr[ADDR_W-1:GRAN_BITS];
    assign unused_low = ^acc_addr[GRAN_BITS-1:0];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        assign vld_mask[g] = s_q.slot[g].vld;
        rsv_slot_cmp #(
            .GRAN_W(GRAN_W), .CPU_W(CPU_W), .THR_W(THR_W)
        ) u_cmp (
            .slot_vld (s_q.slot[g].vld),
            .slot_gran(s_q.slot[g].gran),
            .slot_cpu (s_q.slot[g].cpu),
            .slot_thr (s_q.slot[g].thr),
            .req_gran (req_gran),
            .req_cpu  (acc_cpu),
            .req_thr  (acc_thr),
            .gran_hit (gran_hit[g]),
            .ctx_hit  (ctx_hit[g])
        );
    end

    rsv_age_matrix #(.N(ENTRIES), .IDX_W(IDX_W)) u_age (
        .clk       (clk),
        .rst_n     (rst_n),
        .touch     (do_ll),
        .touch_idx (tgt_idx),
        .vld_mask  (vld_mask),
        .oldest_idx(oldest_idx)
    );

    always_comb begin
        do_ll   = acc_vld && acc_load && acc_locked;
        do_st   = acc_vld && acc_store;
        do_sc   = do_st && acc_locked;
        sc_pass = do_sc && |(gran_hit & ctx_hit);

        wr_permit = do_st && (!acc_locked || sc_pass);

        free_found = 1'b0;
        free_idx   = '0;
        own_found  = 1'b0;
        own_idx    = '0;
        for (int i = ENTRIES-1; i >= 0; i--) begin
            if (!s_q.slot[i].vld) begin
                free_found = 1'b1;
                free_idx   = IDX_W'(i);
            end
            if (ctx_hit[i]) begin
                own_found = 1'b1;
                own_idx   = IDX_W'(i);
            end
        end

        if (own_found) begin
            place   = PLACE_REFRESH;
            tgt_idx = own_idx;
        end else if (free_found) begin
            place   = PLACE_FREE;
            tgt_idx = free_idx;
        end else begin
            place   = PLACE_EVICT;
            tgt_idx = oldest_idx;
        end

        s_d         = s_q;
        s_d.sc_done = do_sc;
        s_d.sc_ok   = sc_pass;

        if (do_st) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (gran_hit[i]) begin
                    s_d.slot[i].vld = 1'b0;
                end
            end
        end

        if (do_ll) begin
            s_d.slot[tgt_idx].vld  = 1'b1;
            s_d.slot[tgt_idx].gran = req_gran;
            s_d.slot[tgt_idx].cpu  = acc_cpu;
            s_d.slot[tgt_idx].thr  = acc_thr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign sc_done = s_q.sc_done;
    assign sc_ok   = s_q.sc_ok;

    // ---------------- checks ----------------
    logic [GRAN_W-1:0]  chk_gran_q;
    logic [ENTRIES-1:0] chk_stale;
    logic               chk_dup;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_gran_q <= '0;
        end else begin
            chk_gran_q <= req_gran;
        end
    end

    always_comb begin
        chk_dup = 1'b0;
        for (int i = 0; i < ENTRIES; i++) begin
            chk_stale[i] = s_q.slot[i].vld && (s_q.slot[i].gran == chk_gran_q);
            for (int j = i + 1; j < ENTRIES; j++) begin
                if (s_q.slot[i].vld && s_q.slot[j].vld &&
                    s_q.slot[i].cpu == s_q.slot[j].cpu &&
                    s_q.slot[i].thr == s_q.slot[j].thr) begin
                    chk_dup = 1'b1;
                end
            end
        end
    end

    AST_LD_ST_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        acc_vld |-> !(acc_load && acc_store)); // R6
    AST_PERMIT_ONLY_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_permit |-> (acc_vld && acc_store)); // R6
    AST_PLAIN_STORE_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_vld && acc_store && !acc_locked) |-> wr_permit); // R6
    AST_EMPTY_SC_FAILS: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_mask == '0 && acc_vld && acc_store && acc_locked) |-> !wr_permit); // R7
    AST_SC_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_vld && acc_store && acc_locked) |=> (sc_done && sc_ok == $past(wr_permit))); // R8
    AST_NO_SC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_vld && acc_store && acc_locked) |=> (!sc_done && !sc_ok)); // R8
    AST_STORE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_vld && acc_store) |=> (chk_stale == '0)); // R4
    AST_ONE_PER_CTX: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_dup); // R2

endmodule

// File: tb/sim_rsv_monitor.sv
`timescale 1ns/1ps
module sim_rsv_monitor;

    localparam int ENT  = 4;
    localparam int OP_LL = 0, OP_LD = 1, OP_ST = 2, OP_SC = 3, OP_IDLE = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_vld = 1'b0;
    logic [31:0] acc_addr = '0;
    logic [1:0]  acc_cpu = '0;
    logic [1:0]  acc_thr = '0;
    logic        acc_load = 1'b0, acc_store = 1'b0, acc_locked = 1'b0;
    logic        wr_permit, sc_done, sc_ok;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    // reference model
    bit mv[ENT];
    int mg[ENT], mc[ENT], mt[ENT], ms[ENT];
    int stamp = 0;

    always #5 clk = ~clk;

    rsv_monitor u0 (
        .clk(clk), .rst_n(rst_n), .acc_vld(acc_vld), .acc_addr(acc_addr),
        .acc_cpu(acc_cpu), .acc_thr(acc_thr), .acc_load(acc_load),
        .acc_store(acc_store), .acc_locked(acc_locked),
        .wr_permit(wr_permit), .sc_done(sc_done), .sc_ok(sc_ok)
    );

    function automatic bit model_pass(int g, int c, int t);
        for (int i = 0; i < ENT; i++)
            if (mv[i] && mg[i] == g && mc[i] == c && mt[i] == t) return 1'b1;
        return 1'b0;
    endfunction

    task automatic model_clear();
        for (int i = 0; i < ENT; i++) mv[i] = 1'b0;
    endtask

    task automatic model_update(int op, int g, int c, int t);
        int k;
        if (op == OP_ST || op == OP_SC)
            for (int i = 0; i < ENT; i++) if (mv[i] && mg[i] == g) mv[i] = 1'b0;
        if (op == OP_LL) begin
            k = -1;
            for (int i = 0; i < ENT; i++) if (mv[i] && mc[i] == c && mt[i] == t) k = i;
            if (k < 0) for (int i = 0; i < ENT; i++) if (!mv[i] && k < 0) k = i;
            if (k < 0) begin
                k = 0;
                for (int i = 1; i < ENT; i++) if (ms[i] < ms[k]) k = i;
            end
            mv[k] = 1'b1; mg[k] = g; mc[k] = c; mt[k] = t; ms[k] = stamp;
            stamp++;
        end
    endtask

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // one access per cycle; entered and left at a negedge
    task automatic acc(string tag, int op, int addr, int c, int t);
        bit exp_pass, exp_perm;
        int g;
        g = addr >>> 4;
        acc_vld    = (op != OP_IDLE);
        acc_addr   = addr[31:0];
        acc_cpu    = c[1:0];
        acc_thr    = t[1:0];
        acc_load   = (op == OP_LL || op == OP_LD);
        acc_store  = (op == OP_ST || op == OP_SC);
        acc_locked = (op == OP_LL || op == OP_SC);
        exp_pass = (op == OP_SC) && model_pass(g, c, t);
        exp_perm = (op == OP_ST) || exp_pass;
        #2;
        check({tag, " permit"}, int'(wr_permit), int'(exp_perm));
        @(posedge clk);
        @(negedge clk);
        check({tag, " sc_done/ok"}, int'({sc_done, sc_ok}),
              int'({(op == OP_SC), exp_pass}));
        model_update(op, g, c, t);
        acc_vld = 1'b0; acc_load = 1'b0; acc_store = 1'b0; acc_locked = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_clear();
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int op, gi, c, t, r;
        int bases[4];
        bases[0] = 'h1000; bases[1] = 'h1010; bases[2] = 'h2000; bases[3] = 'h2020;
        r = $urandom(32'd7);
        model_clear();
        @(negedge clk);
        do_reset();

        check("R10 reset sc_done/ok", int'({sc_done, sc_ok}), 0);
        acc("R7 sc on empty", OP_SC, 'h100, 0, 0);
        acc("R7 plain store on empty", OP_ST, 'h100, 0, 0);

        // R1 granule match, R5 pass
        acc("R1 ll", OP_LL, 'h100, 1, 0);
        acc("R1 sc other byte same granule", OP_SC, 'h10C, 1, 0);
        acc("R4 sc again after own success", OP_SC, 'h100, 1, 0);
        acc("R1 ll", OP_LL, 'h100, 1, 0);
        acc("R1 sc next granule", OP_SC, 'h110, 1, 0);
        acc("R1 sc still held", OP_SC, 'h100, 1, 0);

        // R2 overwrite
        acc("R2 ll a", OP_LL, 'h100, 2, 1);
        acc("R2 ll b", OP_LL, 'h200, 2, 1);
        acc("R2 sc old granule", OP_SC, 'h100, 2, 1);
        acc("R2 sc new granule", OP_SC, 'h204, 2, 1);

        // R4 plain store by third context
        acc("R3 ll ctxA", OP_LL, 'h300, 0, 1);
        acc("R3 ll ctxB", OP_LL, 'h300, 3, 0);
        acc("R4 plain store ctxC", OP_ST, 'h308, 1, 1);
        acc("R4 sc ctxA", OP_SC, 'h300, 0, 1);
        acc("R4 sc ctxB", OP_SC, 'h300, 3, 0);

        // R5 wrong context, which also clears
        acc("R5 ll", OP_LL, 'h400, 0, 0);
        acc("R5 sc foreign", OP_SC, 'h400, 1, 0);
        acc("R4 sc owner after foreign", OP_SC, 'h400, 0, 0);

        // R6 plain load no effect
        acc("R6 ll", OP_LL, 'h500, 2, 0);
        acc("R6 plain load", OP_LD, 'h500, 3, 1);
        acc("R6 idle", OP_IDLE, 'h500, 2, 0);
        acc("R6 sc survives", OP_SC, 'h500, 2, 0);

        // R3/R9 fill and evict
        for (int i = 0; i < 4; i++) acc("R3 fill", OP_LL, 'h600 + 16*i, i, 0);
        acc("R9 fifth ctx", OP_LL, 'h700, 0, 1);
        acc("R9 oldest evicted", OP_SC, 'h600, 0, 0);
        acc("R3 second kept", OP_SC, 'h610, 1, 0);
        do_reset();
        for (int i = 0; i < 4; i++) acc("R3 fill", OP_LL, 'h800 + 16*i, i, 1);
        acc("R9 refresh first", OP_LL, 'h800, 0, 1);
        acc("R9 new ctx", OP_LL, 'h900, 2, 0);
        acc("R9 second evicted", OP_SC, 'h810, 1, 1);
        acc("R9 refreshed kept", OP_SC, 'h800, 0, 1);

        // R10 reset drops reservations
        acc("R10 ll", OP_LL, 'hA00, 3, 1);
        do_reset();
        acc("R10 sc after reset", OP_SC, 'hA00, 3, 1);

        // random
        for (int n = 0; n < 3000; n++) begin
            op = $urandom % 5;
            gi = $urandom % 4;
            c  = $urandom % 4;
            t  = $urandom % 2;
            acc("R5 random", op, bases[gi] + ($urandom % 16), c, t);
        end

        finish_run();
    end

endmodule